// File: doc/BRIEF.md
# Step Attenuator Programming Master

This block sits on the host side of a board-level step attenuator and turns a single code request into the pin activity the attenuator needs. A request carries a 6-bit attenuation code and a mode bit. In serial mode the block shifts the code out on a data line with a software-free generated serial clock, most significant bit first, while the latch enable is held low, then pulses the latch enable high and low to apply the code. In latched parallel mode it drives the code onto six parallel lines and pulses the latch enable around them.

Every edge spacing is derived from minimum times given in nanoseconds together with the system clock period. Each minimum is converted to a whole number of system cycles by rounding up. After each update a guard interval keeps the update rate under the attenuator's limit. Requests use a valid/ready handshake: while a transfer or its guard interval is running the block is not ready, so a waiting request stays pending and is not lost.

Top module: `atten_prog_master`

## Requirements
- R1: In serial mode exactly six serial clock rising edges occur per request, all while latch enable is low, and latch enable pulses high once after them.
- R2: The bit sampled at the k-th rising serial clock edge is code bit 5-k, so the most significant bit goes first and bit 0 goes last.
- R3: Each serial clock high phase lasts at least ceil(30 ns / Tclk) cycles, each low phase between rises at least ceil(30 ns / Tclk) cycles, and successive rises within a request are at least ceil(100 ns / Tclk) cycles apart.
- R4: Serial data changes only while the serial clock is low, at least ceil(10 ns / Tclk) cycles before the next rise and at least ceil(10 ns / Tclk) cycles after the previous fall.
- R5: In serial mode latch enable rises at least ceil(10 ns / Tclk) cycles after the last serial clock fall and stays high for at least ceil(30 ns / Tclk) cycles.
- R6: In parallel mode (mode bit 1) the parallel lines carry the requested code, are stable at least ceil(10 ns / Tclk) cycles before latch enable rises, during the pulse, and at least ceil(10 ns / Tclk) cycles after it falls; the pulse lasts at least ceil(10 ns / Tclk) cycles and no serial clock edge occurs.
- R7: From any latch enable falling edge to the next latch enable rising edge at least ceil(UPDATE_NS / Tclk) cycles pass.
- R8: A request is taken only when ready and valid are both high; ready is low and busy high from the cycle after acceptance until the guard interval ends, and a request held valid meanwhile is carried out afterwards.
- R9: Out of reset and between requests the serial clock, latch enable and serial data are low, busy is low and ready is high.
- R10: Done is a one-cycle pulse per request: in serial mode in the first cycle latch enable is low again, in parallel mode ceil(10 ns / Tclk) cycles after latch enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_mode | input | 1 | 0 serial shift, 1 latched parallel |
| req_code | input | 6 | Attenuation code, bit 5 is the largest step |
| busy | output | 1 | Transfer or guard interval in progress |
| done | output | 1 | One-cycle completion pulse |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_clk | output | 1 | Serial clock to the attenuator |
| latch_en | output | 1 | Latch enable to the attenuator |
| par_code | output | 6 | Parallel control lines |

## Verification
Codes with a single set bit at either end (100000 and 000001) separate most-significant-first order from a reversed shift, while the alternating patterns 101010 and 010101 force a data change on every bit so every setup and hold window is measured. All-zero and all-one codes leave the data line still for a whole transfer, which exposes a clock or latch sequence that depends on data edges. Serial and parallel requests are interleaved and queued back to back, so the guard interval, the hold-off of a pending request and the absence of serial clocking in parallel mode are all observed at the pins.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SLO,    // serial clock low, data presented
    ST_SHI,    // serial clock high
    ST_SHLD,   // serial clock low, data held after fall
    ST_LESU,   // wait before latch enable rise (serial)
    ST_SLE,    // latch enable high (serial)
    ST_PSU,    // parallel lines settle before latch enable
    ST_PLE,    // latch enable high (parallel)
    ST_PHLD,   // parallel lines held after latch enable
    ST_GAP     // guard interval between updates
  } seq_state_e;

  // Minimum time in ns to system clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int at_least(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Low phase before a rise: covers the low-time minimum (part of it is
  // already spent in the hold state), the data setup and the clock period.
  function automatic int low_phase(input int lo, input int su, input int per,
                                   input int hi, input int hld);
    return at_least(at_least(lo - hld, su), at_least(per - hi - hld, 1));
  endfunction

  function automatic int width_for(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/atten_shift_reg.sv
module atten_shift_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] code,
  input  logic         shift,
  input  logic         clear,
  output logic         msb,
  output logic         last
);
  localparam int IW = (W < 2) ? 1 : $clog2(W);

  logic [W-1:0]  sreg_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      sreg_q <= code;
      idx_q  <= '0;
    end else if (clear) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else if (shift) begin
      sreg_q <= {sreg_q[W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign msb  = sreg_q[W-1];
  assign last = (idx_q == IW'(W - 1));
endmodule

// File: rtl/atten_seq_fsm.sv
module atten_seq_fsm
  import atten_prog_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int TW       = 8,
  parameter int L_LO     = 1,
  parameter int L_HI     = 1,
  parameter int L_HLD    = 1,
  parameter int L_LESU   = 1,
  parameter int L_LEPW_S = 1,
  parameter int L_PSU    = 1,
  parameter int L_LEPW_P = 1,
  parameter int L_PHLD   = 1,
  parameter int L_GAP    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_mode,
  input  logic [CODE_W-1:0] req_code,
  input  logic              tmr_exp,
  input  logic              sh_last,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              sh_load,
  output logic              sh_shift,
  output logic              sh_clear,
  output logic              ser_clk,
  output logic              latch_en,
  output logic [CODE_W-1:0] par_code,
  output logic              done,
  output logic              busy,
  output logic              ready,
  output logic              ev_accept
);
  seq_state_e state_q, state_n;
  logic clk_n, le_n, done_n, par_ld;

  assign ready     = (state_q == ST_IDLE);
  assign busy      = !ready;
  assign ev_accept = ready && req_valid;

  always_comb begin
    state_n  = state_q;
    clk_n    = ser_clk;
    le_n     = latch_en;
    done_n   = 1'b0;
    par_ld   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_clear = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (!req_mode) begin
          state_n = ST_SLO;
          tmr_val = TW'(L_LO - 1);
          sh_load = 1'b1;
        end else begin
          state_n = ST_PSU;
          tmr_val = TW'(L_PSU - 1);
          par_ld  = 1'b1;
        end
      end
      ST_SLO: if (tmr_exp) begin
        state_n = ST_SHI; clk_n = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(L_HI - 1);
      end
      ST_SHI: if (tmr_exp) begin
        state_n = ST_SHLD; clk_n = 1'b0;
        tmr_load = 1'b1; tmr_val = TW'(L_HLD - 1);
      end
      ST_SHLD: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (sh_last) begin
          state_n  = ST_LESU; sh_clear = 1'b1;
          tmr_val  = TW'(L_LESU - 1);
        end else begin
          state_n  = ST_SLO; sh_shift = 1'b1;
          tmr_val  = TW'(L_LO - 1);
        end
      end
      ST_LESU: if (tmr_exp) begin
        state_n = ST_SLE; le_n = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(L_LEPW_S - 1);
      end
      ST_SLE: if (tmr_exp) begin
        state_n = ST_GAP; le_n = 1'b0; done_n = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(L_GAP - 1);
      end
      ST_PSU: if (tmr_exp) begin
        state_n = ST_PLE; le_n = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(L_LEPW_P - 1);
      end
      ST_PLE: if (tmr_exp) begin
        state_n = ST_PHLD; le_n = 1'b0;
        tmr_load = 1'b1; tmr_val = TW'(L_PHLD - 1);
      end
      ST_PHLD: if (tmr_exp) begin
        state_n = ST_GAP; done_n = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(L_GAP - 1);
      end
      ST_GAP: if (tmr_exp) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ser_clk  <= 1'b0;
      latch_en <= 1'b0;
      done     <= 1'b0;
      par_code <= '0;
    end else begin
      state_q  <= state_n;
      ser_clk  <= clk_n;
      latch_en <= le_n;
      done     <= done_n;
      if (par_ld) par_code <= req_code;
    end
  end
endmodule

// File: rtl/atten_prog_master.sv
module atten_prog_master
  import atten_prog_pkg::*;
#(
  parameter int CODE_W       = 6,
  parameter int CLK_PS       = 4000,
  parameter int CLK_HI_NS    = 30,
  parameter int CLK_LO_NS    = 30,
  parameter int CLK_PER_NS   = 100,
  parameter int DAT_SU_NS    = 10,
  parameter int DAT_HLD_NS   = 10,
  parameter int LE_SU_NS     = 10,
  parameter int LE_PW_SER_NS = 30,
  parameter int PAR_SU_NS    = 10,
  parameter int PAR_HLD_NS   = 10,
  parameter int LE_PW_PAR_NS = 10,
  parameter int UPDATE_NS    = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mode,
  input  logic [CODE_W-1:0] req_code,
  output logic              busy,
  output logic              done,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              latch_en,
  output logic [CODE_W-1:0] par_code
);
  localparam int L_HI     = ns_to_cyc(CLK_HI_NS, CLK_PS);
  localparam int L_HLD    = ns_to_cyc(DAT_HLD_NS, CLK_PS);
  localparam int L_LO     = low_phase(ns_to_cyc(CLK_LO_NS, CLK_PS),
                                      ns_to_cyc(DAT_SU_NS, CLK_PS),
                                      ns_to_cyc(CLK_PER_NS, CLK_PS),
                                      L_HI, L_HLD);
  localparam int L_LESU   = at_least(ns_to_cyc(LE_SU_NS, CLK_PS) - L_HLD, 1);
  localparam int L_LEPW_S = ns_to_cyc(LE_PW_SER_NS, CLK_PS);
  localparam int L_PSU    = ns_to_cyc(PAR_SU_NS, CLK_PS);
  localparam int L_LEPW_P = ns_to_cyc(LE_PW_PAR_NS, CLK_PS);
  localparam int L_PHLD   = ns_to_cyc(PAR_HLD_NS, CLK_PS);
  localparam int L_GAP    = ns_to_cyc(UPDATE_NS, CLK_PS);
  localparam int L_MAX    = at_least(at_least(at_least(L_LO, L_HI), L_GAP),
                                     at_least(L_LEPW_S, L_LESU));
  localparam int TW       = width_for(at_least(L_MAX,
                              at_least(L_PSU, at_least(L_LEPW_P, L_PHLD))));

  logic          tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          sh_load, sh_shift, sh_clear, sh_last;
  logic          ev_accept;
  logic [15:0]   cfg_hi_min;

  assign cfg_hi_min = 16'(L_HI);

  atten_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_exp)
  );

  atten_shift_reg #(.W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .code(req_code),
    .shift(sh_shift), .clear(sh_clear), .msb(ser_data), .last(sh_last)
  );

  atten_seq_fsm #(
    .CODE_W(CODE_W), .TW(TW), .L_LO(L_LO), .L_HI(L_HI), .L_HLD(L_HLD),
    .L_LESU(L_LESU), .L_LEPW_S(L_LEPW_S), .L_PSU(L_PSU),
    .L_LEPW_P(L_LEPW_P), .L_PHLD(L_PHLD), .L_GAP(L_GAP)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_code(req_code), .tmr_exp(tmr_exp), .sh_last(sh_last),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .sh_load(sh_load),
    .sh_shift(sh_shift), .sh_clear(sh_clear), .ser_clk(ser_clk),
    .latch_en(latch_en), .par_code(par_code), .done(done), .busy(busy),
    .ready(req_ready), .ev_accept(ev_accept)
  );
endmodule

// File: rtl/atten_prog_chk.sv
module atten_prog_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_accept,
  input logic              busy,
  input logic              done,
  input logic              ser_data,
  input logic              ser_clk,
  input logic              latch_en,
  input logic [CODE_W-1:0] par_code,
  input logic [15:0]       hi_min
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else        hi_run <= ser_clk ? hi_run + 16'd1 : 16'd0;
  end

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !latch_en && !ser_data));

  a_r1_le_low_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !latch_en);

  a_r4_data_still_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  a_r3_high_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (hi_run >= hi_min));

  a_r6_par_still_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && $past(latch_en)) |-> $stable(par_code));

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind atten_prog_master atten_prog_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept), .busy(busy), .done(done),
  .ser_data(ser_data), .ser_clk(ser_clk), .latch_en(latch_en),
  .par_code(par_code), .hi_min(cfg_hi_min)
);

// File: tb/atten_prog_master_tb.sv
module atten_prog_master_tb_top;
  localparam int CPS = 4000;
  localparam int UPD = 2000;

  function automatic int need(input int ns);
    int v;
    v = ns * 1000 / CPS;
    if (v * CPS < ns * 1000) v = v + 1;
    if (v == 0) v = 1;
    return v;
  endfunction

  localparam int E_HI = need(30), E_LO = need(30), E_PER = need(100);
  localparam int E_DSU = need(10), E_DHLD = need(10), E_LESU = need(10);
  localparam int E_LEPS = need(30), E_PSU = need(10), E_PHLD = need(10);
  localparam int E_LEPP = need(10), E_GAP = need(UPD);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_mode = 1'b0;
  logic [5:0] req_code = '0;
  logic req_ready, busy, done, ser_data, ser_clk, latch_en;
  logic [5:0] par_code;

  atten_prog_master #(.UPDATE_NS(UPD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_code(req_code), .busy(busy), .done(done),
    .ser_data(ser_data), .ser_clk(ser_clk), .latch_en(latch_en),
    .par_code(par_code)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {mode, code}: mode 0 serial, 1 parallel
  localparam logic [6:0] VEC [12] = '{
    7'b0_100000, 7'b0_000001, 7'b0_101010, 7'b0_010101, 7'b0_111111,
    7'b0_000000, 7'b1_110011, 7'b1_001100, 7'b0_011110, 7'b1_111111,
    7'b1_000000, 7'b0_100001 };

  logic       exp_mode [64];
  logic [5:0] exp_code [64];
  int n_sent = 0;

  // Monitor state
  int cyc = 0, last_rise = -100000, last_fall = -100000, data_chg = -100000;
  int le_rise = -100000, le_fall = -100000, par_chg = -100000;
  int nrise = 0, n_le = 0, n_done = 0;
  logic [5:0] word = '0;
  logic p_clk = 0, p_dat = 0, p_le = 0, p_done = 0;
  logic [5:0] p_par = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ser_data !== p_dat) begin
        chk(ser_clk == 1'b0, "R4 data change while clock high", ser_clk, 0);
        if (nrise > 0)
          chk(cyc - last_fall >= E_DHLD, "R4 hold after fall", cyc - last_fall, E_DHLD);
        data_chg = cyc;
      end
      if (ser_clk && !p_clk) begin
        chk(latch_en == 1'b0, "R1 latch low during shift", latch_en, 0);
        chk(cyc - data_chg >= E_DSU, "R4 setup before rise", cyc - data_chg, E_DSU);
        if (nrise > 0) begin
          chk(cyc - last_fall >= E_LO, "R3 low phase", cyc - last_fall, E_LO);
          chk(cyc - last_rise >= E_PER, "R3 period", cyc - last_rise, E_PER);
        end
        word = {word[4:0], ser_data};
        nrise++;
        last_rise = cyc;
      end
      if (!ser_clk && p_clk) begin
        chk(cyc - last_rise >= E_HI, "R3 high phase", cyc - last_rise, E_HI);
        last_fall = cyc;
      end
      if (par_code !== p_par) begin
        chk(latch_en == 1'b0 && cyc - le_fall >= E_PHLD, "R6 parallel hold",
            cyc - le_fall, E_PHLD);
        par_chg = cyc;
      end
      if (latch_en && !p_le) begin
        if (n_le > 0)
          chk(cyc - le_fall >= E_GAP, "R7 update interval", cyc - le_fall, E_GAP);
        if (!exp_mode[n_le]) begin
          chk(nrise == 6, "R1 six clocks", nrise, 6);
          chk(word == exp_code[n_le], "R2 shifted word", word, exp_code[n_le]);
          chk(cyc - last_fall >= E_LESU, "R5 latch setup", cyc - last_fall, E_LESU);
        end else begin
          chk(nrise == 0, "R6 no serial clock", nrise, 0);
          chk(par_code == exp_code[n_le], "R6 parallel code", par_code, exp_code[n_le]);
          chk(cyc - par_chg >= E_PSU, "R6 parallel setup", cyc - par_chg, E_PSU);
        end
        le_rise = cyc;
        n_le++;
      end
      if (!latch_en && p_le) begin
        if (!exp_mode[n_le-1])
          chk(cyc - le_rise >= E_LEPS, "R5 serial pulse width", cyc - le_rise, E_LEPS);
        else
          chk(cyc - le_rise >= E_LEPP, "R6 parallel pulse width", cyc - le_rise, E_LEPP);
        le_fall = cyc;
        nrise = 0;
        word = '0;
      end
      if (done) begin
        chk(!p_done, "R10 done single cycle", p_done, 0);
        if (n_le > 0) begin
          if (!exp_mode[n_le-1])
            chk(cyc == le_fall, "R10 serial done timing", cyc - le_fall, 0);
          else
            chk(cyc - le_fall == E_PHLD, "R10 parallel done timing", cyc - le_fall, E_PHLD);
        end
        n_done++;
      end
    end
    p_clk = ser_clk; p_dat = ser_data; p_le = latch_en; p_done = done; p_par = par_code;
  end

  task automatic send(input logic m, input logic [5:0] c);
    @(negedge clk);
    exp_mode[n_sent] = m;
    exp_code[n_sent] = c;
    n_sent++;
    req_valid = 1'b1; req_mode = m; req_code = c;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_code = ~c; req_mode = ~m;
    // R8: taken request makes the block busy and not ready
    chk(busy == 1'b1 && req_ready == 1'b0, "R8 busy after accept", busy, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(ser_clk == 0 && latch_en == 0 && ser_data == 0, "R9 idle pins", ser_clk, 0);
    chk(busy == 0 && req_ready == 1 && done == 0, "R9 idle status", busy, 0);
    foreach (VEC[i]) send(VEC[i][6], VEC[i][5:0]);
    // R8: hold a request valid through a busy window, then it must complete
    send(1'b0, 6'b110110);
    @(negedge clk);
    req_valid = 1'b1; req_mode = 1'b1; req_code = 6'b011011;
    exp_mode[n_sent] = 1'b1; exp_code[n_sent] = 6'b011011; n_sent++;
    repeat (20) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R8 not ready while busy", req_ready, 0);
    end
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_le == n_sent, "R8 every request applied", n_le, n_sent);
    chk(n_done == n_sent, "R10 done count", n_done, n_sent);
    chk(ser_clk == 0 && latch_en == 0 && ser_data == 0, "R9 idle after run", latch_en, 0);
    chk(req_ready == 1, "R9 ready after run", req_ready, 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule